// File: doc/BRIEF.md
# Dual-Compare Interval Timer

A single up-counting timer channel with two compare values. Compare B sets the period: when the count reaches it, the count goes back to zero. Compare A sets an edge inside that period. Together they produce a pulse-width waveform on one output pin. Each match also gives a one-cycle interrupt pulse. The count advances only on cycles where an external count strobe and the software run bit are both high. When the timer is stopped, the count holds its value.

Software reaches three words through a small register port. Each word has a 2-bit address. Writes are taken on the clock edge, and reads are combinational. Word 0 is control: bit 0 is run, bit 1 is invert and bit 2 is buffer mode. Word 1 is compare A and word 2 is compare B. Word 3 reads as zero, and writes to it are ignored. In buffer mode, compare accesses go to shadow copies. These copies move into the live compares when the counter restarts, so a new period or duty takes effect cleanly.

Top module: `dual_cmp_timer`

## Requirements
- R1: The run bit (control bit 0) resets to 0. Writing 1 starts counting and writing 0 stops it. The control word reads back as {buffer mode, invert, run} in bits 2..0.
- R2: The count advances by one only on a cycle where count_en and run are both 1. A stopped counter holds its value, and setting run again resumes from that value.
- R3: On a count step where the count equals compare A, irq_a pulses and the output goes to its active level (high, or low when inverted). The count keeps advancing.
- R4: On a count step where the count equals compare B, irq_b pulses, the output goes to its inactive level and the count becomes 0.
- R5: When both compares match on the same step, both interrupts pulse and the output takes the inactive level.
- R6: With buffer mode 0, compare writes and reads at words 1 and 2 access the live compare values.
- R7: With buffer mode 1, compare writes and reads access shadow values. The shadow values are copied into the live compares on every counter restart.
- R8: A step at the all-ones count with no compare B match wraps the count to 0. That wrap counts as a restart for loading the shadow values.
- R9: After reset the output is low. The output equals the internal level XOR the invert bit, so a write to the invert bit flips the output in the next cycle.
- R10: An interrupt is high only in the cycle after the matching step. A step without a match, or a cycle without a step, leaves both interrupts low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_en | input | 1 | Count strobe, one step per high cycle while running |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word select for reads and writes |
| wr_data | input | W | Write data |
| rd_data | output | W | Read data of the addressed word |
| wave_out | output | 1 | Timer waveform |
| irq_a | output | 1 | Compare A match pulse |
| irq_b | output | 1 | Compare B match pulse |

## Verification
Two things can land on the same count step: a compare A match together with a compare B match, and a compare B match together with the restart that loads the shadow compares. The bench sweeps every pair of compare values on a 4-bit counter, including every pair where A equals B. On those pairs it expects both interrupts and the inactive output level. A second sequence writes shadow values in the middle of a period, then forces first a wrap and later a B match. Each interrupt is compared step by step against an arithmetic count model, which shows on which step the new compares take effect.

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         count_en,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         wave_out,
  output logic         irq_a,
  output logic         irq_b
);
  localparam logic [W-1:0] TOP = '1;

  logic         run_q, inv_q, sel_q, lvl;
  logic [W-1:0] cnt, act_a, act_b, buf_a, buf_b;
  logic         step, hit_a, hit_b, reload;
  logic         wr_ctl, wr_a, wr_b;

  assign step   = count_en & run_q;
  assign hit_a  = step && (cnt == act_a);
  assign hit_b  = step && (cnt == act_b);
  assign reload = hit_b || (step && cnt == TOP);
  assign wr_ctl = wr_en && addr == 2'd0;
  assign wr_a   = wr_en && addr == 2'd1;
  assign wr_b   = wr_en && addr == 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      inv_q <= 1'b0;
      sel_q <= 1'b0;
    end else if (wr_ctl) begin
      run_q <= wr_data[0];
      inv_q <= wr_data[1];
      sel_q <= wr_data[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      lvl   <= 1'b0;
      irq_a <= 1'b0;
      irq_b <= 1'b0;
    end else begin
      irq_a <= hit_a;
      irq_b <= hit_b;
      if (hit_b)     cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
      if (hit_b)      lvl <= 1'b0;
      else if (hit_a) lvl <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_a && !sel_q)       act_a <= wr_data;
    else if (reload && sel_q) act_a <= buf_a;
    if (wr_b && !sel_q)       act_b <= wr_data;
    else if (reload && sel_q) act_b <= buf_b;
    if (wr_a && sel_q) buf_a <= wr_data;
    if (wr_b && sel_q) buf_b <= wr_data;
  end

  always_comb begin
    case (addr)
      2'd0:    rd_data = {{(W-3){1'b0}}, sel_q, inv_q, run_q};
      2'd1:    rd_data = sel_q ? buf_a : act_a;
      2'd2:    rd_data = sel_q ? buf_b : act_b;
      default: rd_data = '0;
    endcase
  end

  assign wave_out = lvl ^ inv_q;

  // R2
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(count_en && run_q) |=> $stable(cnt));
  // R4
  b_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b |-> (cnt == '0 && wave_out == inv_q));
  // R3
  a_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a && !irq_b) |-> (wave_out != inv_q));
  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a || irq_b) |-> $past(count_en && run_q));
  // R1
  run_reset_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!run_q && !wave_out));
endmodule

// File: tb/sim_dual_cmp_timer.sv
`timescale 1ns/1ps
module sim_dual_cmp_timer;
  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, count_en = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic wave_out, irq_a, irq_b;

  dual_cmp_timer #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .wave_out(wave_out), .irq_a(irq_a), .irq_b(irq_b));

  always #4 clk = ~clk;

  int total = 0, fails = 0, cycles = 0;
  int m_cnt, m_a, m_b, m_ba, m_bb;
  bit m_run, m_inv, m_sel, m_lvl;

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 200000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      report();
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; m_lvl = 0; m_run = 0; m_inv = 0; m_sel = 0;
    chk(wave_out == 1'b0, "R9 reset level", wave_out, 0);
    addr = 2'd0;
    #1 chk(rd_data == 0, "R1 reset control", rd_data, 0);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; addr = a[1:0]; wr_data = d[W-1:0];
    @(posedge clk);
    if (a == 0) begin m_run = d[0]; m_inv = d[1]; m_sel = d[2]; end
    else if (a == 1) begin if (m_sel) m_ba = d; else m_a = d; end
    else if (a == 2) begin if (m_sel) m_bb = d; else m_b = d; end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(int a, string tag);
    int exp;
    case (a)
      0: exp = {m_sel, m_inv, m_run};
      1: exp = m_sel ? m_ba : m_a;
      2: exp = m_sel ? m_bb : m_b;
      default: exp = 0;
    endcase
    addr = a[1:0];
    #1 chk(rd_data == exp[W-1:0], tag, rd_data, exp);
  endtask

  task automatic step(bit en, string tag);
    bit ea, eb;
    int v;
    count_en = en;
    @(posedge clk);
    ea = 0; eb = 0;
    if (en && m_run) begin
      v = m_cnt;
      ea = (v == m_a);
      eb = (v == m_b);
      if (eb) m_lvl = 0;
      else if (ea) m_lvl = 1;
      m_cnt = eb ? 0 : (v + 1) & MAXV;
      if ((eb || v == MAXV) && m_sel) begin m_a = m_ba; m_b = m_bb; end
    end
    @(negedge clk);
    count_en = 1'b0;
    chk(irq_a == ea, {tag, " irq_a"}, irq_a, ea);
    chk(irq_b == eb, {tag, " irq_b"}, irq_b, eb);
    chk(wave_out == (m_lvl ^ m_inv), {tag, " wave"}, wave_out, m_lvl ^ m_inv);
  endtask

  initial begin
    @(negedge clk);
    for (int a = 0; a <= MAXV; a++) begin
      for (int b = 0; b <= MAXV; b++) begin
        do_reset();
        wr(1, a);
        wr(2, b);
        rdchk(1, "R6 read A");
        rdchk(2, "R6 read B");
        wr(0, 1 | (((a ^ b) & 1) << 1));
        rdchk(0, "R1 control");
        for (int k = 0; k < 20; k++) begin
          if (k % 5 == 3) step(1'b0, "R10 idle");
          else step(1'b1, (a == b) ? "R5" : ((k & 1) ? "R3" : "R4"));
        end
      end
    end

    // R2 stop and resume
    do_reset();
    wr(1, 3); wr(2, 9); wr(0, 1);
    for (int k = 0; k < 4; k++) step(1'b1, "R2 run");
    wr(0, 0);
    rdchk(0, "R1 stopped");
    for (int k = 0; k < 5; k++) step(1'b1, "R2 held");
    wr(0, 1);
    for (int k = 0; k < 8; k++) step(1'b1, "R2 resume");

    // R9 invert flips the current level at once
    wr(0, 3);
    chk(wave_out == (m_lvl ^ 1'b1), "R9 invert flip", wave_out, m_lvl ^ 1'b1);
    wr(0, 1);
    chk(wave_out == m_lvl, "R9 invert back", wave_out, m_lvl);

    // R8 wrap with shadow load
    do_reset();
    wr(1, 12); wr(2, 10); wr(0, 1);
    for (int k = 0; k < 6; k++) step(1'b1, "R8 pre");
    wr(2, 2);
    wr(0, 5);
    wr(1, 1); wr(2, 4);
    rdchk(1, "R7 read shadow A");
    rdchk(2, "R7 read shadow B");
    for (int k = 0; k < 16; k++) step(1'b1, "R8 wrap");

    // R7 shadow load on B match
    wr(1, 5); wr(2, 7);
    for (int k = 0; k < 14; k++) step(1'b1, "R7 load");
    wr(0, 1);
    rdchk(1, "R6 live A");
    rdchk(2, "R6 live B");
    for (int k = 0; k < 4; k++) step(1'b1, "R6 direct");

    report();
  end
endmodule